// File: doc/BRIEF.md
# Raster Line and Frame Timing Generator

This block is the timebase of a character display with a fixed interlace-free raster. It counts CPU clock cycles across each raster line and raster lines across each frame. From those two counts it derives the horizontal and vertical blanking flags and a logical display-line index. That index advances once for every pair of raster lines, so each stored scanline is shown twice. It also derives the character row and the scanline-in-row of a text window that sits above the vertical centre of the visible area.

Once per frame the block raises a non-maskable frame interrupt toward the CPU. It does this at the moment the last visible raster line ends, not when the whole frame ends. Software therefore gets the full vertical blanking interval to update the screen. The defaults are as follows:

- 190 cycles per line
- 625 lines per frame, of which the first 576 are visible
- a display line repeat of two
- character rows eight display lines tall
- 5 border rows above a 24-row text window and 7 border rows below it

Top module: `raster_timing`

## Requirements
- R1: A synchronous reset, active high on `rst`, sets the state to cycle 0 of line 1 with `nmi` low and `disp_line` at 0. The first clock edge with `rst` low moves the state to cycle 1.
- R2: `cyc_cnt` counts 0 to 189 and then returns to 0. `line_cnt` advances by one exactly when `cyc_cnt` wraps and holds its value in every other cycle.
- R3: `line_cnt` runs from 1 to 625. After cycle 189 of line 625 it returns to 1.
- R4: `vblank` is 1 on lines 577 to 625 inclusive and 0 on lines 1 to 576.
- R5: `hblank` is 1 when `cyc_cnt` is 160 or more and 0 when `cyc_cnt` is 159 or less.
- R6: `nmi` is 1 for exactly one cycle per frame, the cycle in which the counters read line 577, cycle 0. It is 0 at every other point, including the last cycle of line 576.
- R7: On visible lines `disp_line` equals (line_cnt − 1) / 2, rounded down, giving 0 to 287. During vertical blanking it reads 0.
- R8: `text_active` is 1 exactly on raster lines 81 to 464, which are display lines 40 to 231. Lines 1 to 80 form a border of 5 character rows, and lines 465 to 576 form a border of 7 character rows.
- R9: While `text_active` is 1, `text_row` = (disp_line − 40) / 8 and `text_scan` = (disp_line − 40) mod 8. While it is 0, both outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; one count per cycle |
| rst | input | 1 | Synchronous reset, active high |
| cyc_cnt | output | 8 | Cycle position within the current raster line |
| line_cnt | output | 10 | Raster line number, starting at 1 |
| hblank | output | 1 | Horizontal blanking active |
| vblank | output | 1 | Vertical blanking active |
| disp_line | output | 9 | Logical display line after line doubling |
| text_row | output | 5 | Character row within the text window |
| text_scan | output | 3 | Scanline within the current character row |
| text_active | output | 1 | Raster position lies inside the text window |
| nmi | output | 1 | Frame interrupt pulse |

## Verification
Every count-derived output, namely the blanking flags, the display line, the text row and scan, and the window flag, belongs to the same cycle as the counter values shown beside it. The frame interrupt is registered on the closing edge of line 576, so it appears in the first cycle that reads line 577, cycle 0. The bench numbers the cycles since reset release as an index k. From the requirements alone it computes the cycle and line that k implies, and then every expected output. Checkpoints are queued by k and compared at the falling edge of that same cycle, so a design that is off by a single cycle at a line boundary, in the doubling phase or at the interrupt edge is caught.

// File: rtl/raster_pkg.sv
package raster_pkg;

   // Default raster geometry
   localparam int unsigned RST_CYC_PER_LINE = 190;
   localparam int unsigned RST_H_ACTIVE     = 160;
   localparam int unsigned RST_LINES        = 625;
   localparam int unsigned RST_VIS_LINES    = 576;
   localparam int unsigned RST_LINE_REPEAT  = 2;
   localparam int unsigned RST_ROW_SCAN     = 8;
   localparam int unsigned RST_TOP_ROWS     = 5;
   localparam int unsigned RST_TEXT_ROWS    = 24;
   localparam int unsigned RST_BOTTOM_ROWS  = 7;
   localparam int unsigned RST_NMI_CYCLES   = 1;

   // Line-level events handed from the vertical counter to its consumers
   typedef struct packed {
      logic last_vis;   // current line is the final visible line
      logic in_vblank;  // current line lies in vertical blanking
   } vline_evt_t;

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
   parameter int unsigned CYC_PER_LINE = raster_pkg::RST_CYC_PER_LINE,
   parameter int unsigned H_ACTIVE     = raster_pkg::RST_H_ACTIVE
) (
   input  logic                            clk,
   input  logic                            rst,
   output logic [$clog2(CYC_PER_LINE)-1:0] cyc,
   output logic                            hblank,
   output logic                            line_end
);
   localparam int unsigned CW = $clog2(CYC_PER_LINE);

   if (CYC_PER_LINE < 2) begin : g_bad_len
      $error("raster_hcount: CYC_PER_LINE must be at least 2");
   end
   if (H_ACTIVE == 0 || H_ACTIVE >= CYC_PER_LINE) begin : g_bad_act
      $error("raster_hcount: H_ACTIVE must lie inside the line");
   end

   assign line_end = (cyc == CW'(CYC_PER_LINE - 1));
   assign hblank   = (cyc >= CW'(H_ACTIVE));

   always_ff @(posedge clk) begin
      if (rst)           cyc <= '0;
      else if (line_end) cyc <= '0;
      else               cyc <= cyc + CW'(1);
   end
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
   import raster_pkg::*;
#(
   parameter int unsigned LINES     = raster_pkg::RST_LINES,
   parameter int unsigned VIS_LINES = raster_pkg::RST_VIS_LINES
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         line_end,
   output logic [$clog2(LINES+1)-1:0]   line,
   output vline_evt_t                   evt
);
   localparam int unsigned LW = $clog2(LINES + 1);

   if (VIS_LINES == 0 || VIS_LINES >= LINES) begin : g_bad_vis
      $error("raster_vcount: VIS_LINES must be below LINES");
   end

   logic last_line;
   assign last_line     = (line == LW'(LINES));
   assign evt.last_vis  = (line == LW'(VIS_LINES));
   assign evt.in_vblank = (line >  LW'(VIS_LINES));

   always_ff @(posedge clk) begin
      if (rst) begin
         line <= LW'(1);
      end else if (line_end) begin
         if (last_line) line <= LW'(1);
         else           line <= line + LW'(1);
      end
   end
endmodule

// File: rtl/raster_nmi.sv
module raster_nmi #(
   parameter int unsigned NMI_CYCLES = raster_pkg::RST_NMI_CYCLES
) (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   output logic nmi
);
   if (NMI_CYCLES == 0) begin : g_bad_w
      $error("raster_nmi: NMI_CYCLES must be at least 1");
   end

   if (NMI_CYCLES == 1) begin : g_shot
      // Single-cycle strobe: one flop
      always_ff @(posedge clk) begin
         if (rst) nmi <= 1'b0;
         else     nmi <= fire;
      end
   end else begin : g_hold
      localparam int unsigned NW = $clog2(NMI_CYCLES + 1);
      logic [NW-1:0] left;
      always_ff @(posedge clk) begin
         if (rst)               left <= '0;
         else if (fire)         left <= NW'(NMI_CYCLES);
         else if (left != '0)   left <= left - NW'(1);
      end
      assign nmi = (left != '0);
   end
endmodule

// File: rtl/raster_textwin.sv
module raster_textwin
   import raster_pkg::*;
#(
   parameter int unsigned VIS_LINES   = raster_pkg::RST_VIS_LINES,
   parameter int unsigned LINE_REPEAT = raster_pkg::RST_LINE_REPEAT,
   parameter int unsigned ROW_SCAN    = raster_pkg::RST_ROW_SCAN,
   parameter int unsigned TOP_ROWS    = raster_pkg::RST_TOP_ROWS,
   parameter int unsigned TEXT_ROWS   = raster_pkg::RST_TEXT_ROWS,
   parameter int unsigned BOTTOM_ROWS = raster_pkg::RST_BOTTOM_ROWS
) (
   input  logic                                      clk,
   input  logic                                      rst,
   input  logic                                      line_end,
   input  vline_evt_t                                evt,
   output logic [$clog2(VIS_LINES/LINE_REPEAT)-1:0]  disp_line,
   output logic [$clog2(TEXT_ROWS)-1:0]              text_row,
   output logic [$clog2(ROW_SCAN)-1:0]               text_scan,
   output logic                                      text_active
);
   localparam int unsigned DISP_LINES = VIS_LINES / LINE_REPEAT;
   localparam int unsigned DW         = $clog2(DISP_LINES);
   localparam int unsigned RW         = $clog2(TEXT_ROWS);
   localparam int unsigned SW         = $clog2(ROW_SCAN);
   localparam int unsigned TXT_FIRST  = TOP_ROWS * ROW_SCAN;
   localparam int unsigned TXT_END    = TXT_FIRST + TEXT_ROWS * ROW_SCAN;

   if ((TOP_ROWS + TEXT_ROWS + BOTTOM_ROWS) * ROW_SCAN * LINE_REPEAT != VIS_LINES) begin : g_bad_sum
      $error("raster_textwin: border and text rows do not fill the visible area");
   end
   if (ROW_SCAN < 2 || (1 << SW) != ROW_SCAN) begin : g_bad_scan
      $error("raster_textwin: ROW_SCAN must be a power of two of at least 2");
   end
   if (TEXT_ROWS < 2 || SW + RW > DW) begin : g_bad_rows
      $error("raster_textwin: text row field does not fit the display line");
   end
   if (LINE_REPEAT == 0) begin : g_bad_rep
      $error("raster_textwin: LINE_REPEAT must be at least 1");
   end

   logic restart;
   assign restart = evt.last_vis | evt.in_vblank;

   if (LINE_REPEAT == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (rst)               disp_line <= '0;
         else if (line_end) begin
            if (restart)        disp_line <= '0;
            else                disp_line <= disp_line + DW'(1);
         end
      end
   end else begin : g_repeat
      localparam int unsigned PW = $clog2(LINE_REPEAT);
      logic [PW-1:0] phase;
      always_ff @(posedge clk) begin
         if (rst) begin
            phase     <= '0;
            disp_line <= '0;
         end else if (line_end) begin
            if (restart) begin
               phase     <= '0;
               disp_line <= '0;
            end else if (phase == PW'(LINE_REPEAT - 1)) begin
               phase     <= '0;
               disp_line <= disp_line + DW'(1);
            end else begin
               phase     <= phase + PW'(1);
            end
         end
      end
   end

   logic [DW-1:0] offset;
   assign offset      = disp_line - DW'(TXT_FIRST);
   assign text_active = !evt.in_vblank &&
                        (disp_line >= DW'(TXT_FIRST)) &&
                        (disp_line <  DW'(TXT_END));
   assign text_row    = text_active ? offset[SW +: RW] : '0;
   assign text_scan   = text_active ? offset[SW-1:0]   : '0;
endmodule

// File: rtl/raster_timing.sv
module raster_timing
   import raster_pkg::*;
#(
   parameter int unsigned CYC_PER_LINE = raster_pkg::RST_CYC_PER_LINE,
   parameter int unsigned H_ACTIVE     = raster_pkg::RST_H_ACTIVE,
   parameter int unsigned LINES        = raster_pkg::RST_LINES,
   parameter int unsigned VIS_LINES    = raster_pkg::RST_VIS_LINES,
   parameter int unsigned LINE_REPEAT  = raster_pkg::RST_LINE_REPEAT,
   parameter int unsigned ROW_SCAN     = raster_pkg::RST_ROW_SCAN,
   parameter int unsigned TOP_ROWS     = raster_pkg::RST_TOP_ROWS,
   parameter int unsigned TEXT_ROWS    = raster_pkg::RST_TEXT_ROWS,
   parameter int unsigned BOTTOM_ROWS  = raster_pkg::RST_BOTTOM_ROWS,
   parameter int unsigned NMI_CYCLES   = raster_pkg::RST_NMI_CYCLES
) (
   input  logic                                      clk,
   input  logic                                      rst,
   output logic [$clog2(CYC_PER_LINE)-1:0]           cyc_cnt,
   output logic [$clog2(LINES+1)-1:0]                line_cnt,
   output logic                                      hblank,
   output logic                                      vblank,
   output logic [$clog2(VIS_LINES/LINE_REPEAT)-1:0]  disp_line,
   output logic [$clog2(TEXT_ROWS)-1:0]              text_row,
   output logic [$clog2(ROW_SCAN)-1:0]               text_scan,
   output logic                                      text_active,
   output logic                                      nmi
);
   logic       line_end;
   vline_evt_t evt;
   logic       nmi_fire;

   raster_hcount #(
      .CYC_PER_LINE(CYC_PER_LINE),
      .H_ACTIVE    (H_ACTIVE)
   ) u_h (
      .clk     (clk),
      .rst     (rst),
      .cyc     (cyc_cnt),
      .hblank  (hblank),
      .line_end(line_end)
   );

   raster_vcount #(
      .LINES    (LINES),
      .VIS_LINES(VIS_LINES)
   ) u_v (
      .clk     (clk),
      .rst     (rst),
      .line_end(line_end),
      .line    (line_cnt),
      .evt     (evt)
   );

   assign vblank   = evt.in_vblank;
   assign nmi_fire = line_end & evt.last_vis;

   raster_nmi #(
      .NMI_CYCLES(NMI_CYCLES)
   ) u_nmi (
      .clk (clk),
      .rst (rst),
      .fire(nmi_fire),
      .nmi (nmi)
   );

   raster_textwin #(
      .VIS_LINES  (VIS_LINES),
      .LINE_REPEAT(LINE_REPEAT),
      .ROW_SCAN   (ROW_SCAN),
      .TOP_ROWS   (TOP_ROWS),
      .TEXT_ROWS  (TEXT_ROWS),
      .BOTTOM_ROWS(BOTTOM_ROWS)
   ) u_txt (
      .clk        (clk),
      .rst        (rst),
      .line_end   (line_end),
      .evt        (evt),
      .disp_line  (disp_line),
      .text_row   (text_row),
      .text_scan  (text_scan),
      .text_active(text_active)
   );
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
   parameter int unsigned CYC_PER_LINE = 190,
   parameter int unsigned H_ACTIVE     = 160,
   parameter int unsigned LINES        = 625,
   parameter int unsigned VIS_LINES    = 576,
   parameter int unsigned LINE_REPEAT  = 2,
   parameter int unsigned TEXT_ROWS    = 24,
   parameter int unsigned ROW_SCAN     = 8
) (
   input logic                                      clk,
   input logic                                      rst,
   input logic [$clog2(CYC_PER_LINE)-1:0]           cyc_cnt,
   input logic [$clog2(LINES+1)-1:0]                line_cnt,
   input logic                                      hblank,
   input logic                                      vblank,
   input logic [$clog2(VIS_LINES/LINE_REPEAT)-1:0]  disp_line,
   input logic [$clog2(TEXT_ROWS)-1:0]              text_row,
   input logic [$clog2(ROW_SCAN)-1:0]               text_scan,
   input logic                                      text_active,
   input logic                                      nmi
);
   localparam int unsigned CW = $clog2(CYC_PER_LINE);
   localparam int unsigned LW = $clog2(LINES + 1);
   localparam int unsigned DW = $clog2(VIS_LINES / LINE_REPEAT);
   localparam int unsigned RW = $clog2(TEXT_ROWS);

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (cyc_cnt == '0 && line_cnt == LW'(1) && !nmi && disp_line == '0)); // R1
   AST_CYC_WRAP: assert property (@(posedge clk) disable iff (rst)
      cyc_cnt == CW'(CYC_PER_LINE - 1) |=> cyc_cnt == '0); // R2
   AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
      cyc_cnt != CW'(CYC_PER_LINE - 1) |=> $stable(line_cnt)); // R2
   AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
      line_cnt >= LW'(1) && line_cnt <= LW'(LINES)); // R3
   AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
      (line_cnt == LW'(LINES) && cyc_cnt == CW'(CYC_PER_LINE - 1)) |=> line_cnt == LW'(1)); // R3
   AST_VBLANK_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(vblank) |-> (line_cnt == LW'(VIS_LINES + 1) && cyc_cnt == '0)); // R4
   AST_VBLANK_FALL: assert property (@(posedge clk) disable iff (rst)
      $fell(vblank) |-> (line_cnt == LW'(1) && cyc_cnt == '0)); // R4
   AST_HBLANK_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(hblank) |-> cyc_cnt == CW'(H_ACTIVE)); // R5
   AST_NMI_START: assert property (@(posedge clk) disable iff (rst)
      $rose(nmi) |-> (line_cnt == LW'(VIS_LINES + 1) && cyc_cnt == '0)); // R6
   AST_NMI_IN_VBLANK: assert property (@(posedge clk) disable iff (rst)
      nmi |-> vblank); // R6
   AST_DISP_HOLD: assert property (@(posedge clk) disable iff (rst)
      cyc_cnt != '0 |-> $stable(disp_line)); // R7
   AST_DISP_STEP: assert property (@(posedge clk) disable iff (rst)
      (cyc_cnt == '0 && !vblank && line_cnt != LW'(1)) |->
      (disp_line == $past(disp_line) || disp_line == $past(disp_line) + DW'(1))); // R7
   AST_DISP_VBLANK: assert property (@(posedge clk) disable iff (rst)
      vblank |-> disp_line == '0); // R7
   AST_TEXT_VBLANK: assert property (@(posedge clk) disable iff (rst)
      vblank |-> !text_active); // R8
   AST_ROW_BOUND: assert property (@(posedge clk) disable iff (rst)
      text_active |-> text_row < RW'(TEXT_ROWS)); // R9
   AST_TEXT_IDLE: assert property (@(posedge clk) disable iff (rst)
      !text_active |-> (text_row == '0 && text_scan == '0)); // R9
endmodule

bind raster_timing raster_timing_chk #(
   .CYC_PER_LINE(CYC_PER_LINE),
   .H_ACTIVE    (H_ACTIVE),
   .LINES       (LINES),
   .VIS_LINES   (VIS_LINES),
   .LINE_REPEAT (LINE_REPEAT),
   .TEXT_ROWS   (TEXT_ROWS),
   .ROW_SCAN    (ROW_SCAN)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cyc_cnt    (cyc_cnt),
   .line_cnt   (line_cnt),
   .hblank     (hblank),
   .vblank     (vblank),
   .disp_line  (disp_line),
   .text_row   (text_row),
   .text_scan  (text_scan),
   .text_active(text_active),
   .nmi        (nmi)
);

// File: tb/sim_raster_timing.sv
`timescale 1ns/1ps
module sim_raster_timing;
   localparam int CPL   = 190;
   localparam int NLN   = 625;
   localparam int FRAME = CPL * NLN;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] cyc_cnt;
   logic [9:0] line_cnt;
   logic       hblank, vblank, text_active, nmi;
   logic [8:0] disp_line;
   logic [4:0] text_row;
   logic [2:0] text_scan;

   always #4 clk = ~clk;

   raster_timing u0 (
      .clk(clk), .rst(rst), .cyc_cnt(cyc_cnt), .line_cnt(line_cnt),
      .hblank(hblank), .vblank(vblank), .disp_line(disp_line),
      .text_row(text_row), .text_scan(text_scan),
      .text_active(text_active), .nmi(nmi)
   );

   // expected layout: cyc, line, hblank, vblank, nmi, disp, row, scan, active
   typedef logic [38:0] obs_t;

   int    n_run  = 0;
   int    n_fail = 0;
   int    k      = 0;
   int    nmi_seen = 0;
   bit    done   = 0;
   int    q_k[$];
   string q_tag[$];
   obs_t  q_exp[$];

   function automatic obs_t model(int kk);
      int c, l, d, off, rw, sc;
      bit hb, vb, nm, ta;
      c  = kk % CPL;
      l  = (kk / CPL) % NLN + 1;
      hb = (c >= 160);
      vb = (l > 576);
      nm = (l == 577 && c == 0);
      d  = vb ? 0 : (l - 1) / 2;
      ta = !vb && d >= 40 && d < 232;
      off = d - 40;
      rw = ta ? off / 8 : 0;
      sc = ta ? off % 8 : 0;
      return {c[7:0], l[9:0], hb, vb, nm, d[8:0], rw[4:0], sc[2:0], ta};
   endfunction

   task automatic expect_at(int kk, string tag);
      q_k.push_back(kk);
      q_tag.push_back(tag);
      q_exp.push_back(model(kk));
   endtask

   task automatic check(bit ok, string tag, string act, string exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%s expected=%s", tag, act, exp);
      end
   endtask

   // monitor: pops checkpoints when their cycle index comes round
   always @(negedge clk) begin
      if (rst) k = 0;
      else begin
         if (nmi && k < FRAME) nmi_seen++;
         if (q_k.size() > 0 && q_k[0] == k) begin
            obs_t act, exp;
            string tag;
            act = {cyc_cnt, line_cnt, hblank, vblank, nmi, disp_line,
                   text_row, text_scan, text_active};
            exp = q_exp.pop_front();
            tag = q_tag.pop_front();
            void'(q_k.pop_front());
            check(act === exp, tag, $sformatf("%h", act), $sformatf("%h", exp));
         end
         k++;
      end
   end

   initial begin
      expect_at(0,      "R1 reset state");
      expect_at(1,      "R1 first step");
      expect_at(159,    "R5 last active cycle");
      expect_at(160,    "R5 first blank cycle");
      expect_at(189,    "R2 last cycle of line");
      expect_at(190,    "R2 line advance");
      expect_at(570,    "R7 line 4 doubled index");
      expect_at(79*CPL, "R8 top border last line");
      expect_at(80*CPL, "R8 text first line");
      expect_at(99*CPL+5,    "R9 row 1 scan 1");
      expect_at(299*CPL+170, "R9 mid window");
      expect_at(463*CPL+189, "R8 text last line");
      expect_at(464*CPL,     "R8 bottom border");
      expect_at(575*CPL+50,  "R7 last display line");
      expect_at(575*CPL+189, "R6 no nmi on line 576");
      expect_at(576*CPL,     "R6 nmi at line 577");
      expect_at(576*CPL+1,   "R6 nmi one cycle");
      expect_at(624*CPL+189, "R4 last blank line");
      expect_at(FRAME,       "R3 wrap to line 1");
      expect_at(FRAME+1,     "R3 after wrap");
      // after mid-run reset the index restarts at zero
      expect_at(0,   "R1 reset mid-line");
      expect_at(1,   "R1 restart step");
      expect_at(190, "R2 line after restart");

      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      repeat (FRAME + 10) @(posedge clk);
      #1 rst = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      repeat (200) @(posedge clk);
      #1;
      check(nmi_seen == 1, "R6 nmi count per frame",
            $sformatf("%0d", nmi_seen), "1");
      check(q_k.size() == 0, "R2 scoreboard drained",
            $sformatf("%0d", q_k.size()), "0");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule